// File: doc/BRIEF.md
# Parallel Lane Prefix-Scan Unit

This block takes a vector of `LANES` unsigned values, one per lane, and returns the running sum across the lanes. Lane `i` of the result is either the sum of lanes `0` through `i` (inclusive mode) or the sum of lanes `0` through `i-1` (exclusive mode). The caller chooses the mode with every request. The sum is built by a log-depth doubling network. At stage `k`, each lane whose index is at least `2^k` adds the previous stage's value of the lane `2^k` below it, and every lower lane passes its value through unchanged. All additions wrap modulo `2^W`.

A register follows each of the `log2(LANES)` stages, so the unit accepts one vector per cycle and returns it `log2(LANES)` cycles later. The mode flag is carried down the pipeline beside its data. The last stage's inclusive result is turned into an exclusive one by moving it up one lane, which puts zero in lane 0.

Both sides use a valid/ready handshake. A vector is accepted when `in_valid` and `in_ready` are both high, and it is delivered when `out_valid` and `out_ready` are both high. The pipeline moves only while `out_ready` is high, so `in_ready` simply follows `out_ready`. While `out_ready` is low, every stage keeps its contents and the presented output stays fixed.

Top module: `lane_scan_unit`

## Requirements
- R1: In inclusive mode (`in_excl` = 0), output lane `i` equals the sum of input lanes `0..i`. Input lanes 1, 2, 3, ..., 8 give outputs 1, 3, 6, 10, 15, 21, 28, 36. Lane `i` occupies bits `[i*W +: W]` of each packed vector.
- R2: In exclusive mode (`in_excl` = 1), output lane 0 is zero and output lane `i` equals the sum of input lanes `0..i-1`.
- R3: The mode applies to each request individually. Back-to-back requests in different modes each produce their own mode's result.
- R4: All sums wrap modulo `2^W`.
- R5: With `out_ready` held high, a vector accepted at a clock edge appears with `out_valid` high exactly `log2(LANES)` clock edges later.
- R6: Vectors offered on consecutive cycles are all accepted, and their results leave in order on consecutive cycles.
- R7: While `out_ready` is low, `in_ready` is low, and `out_valid` and `out_data` keep their values.
- R8: During and after reset, before any vector is accepted, `out_valid` is low and `in_ready` equals `out_ready`.
- R9: In every stage, the lanes below that stage's offset leave the stage unchanged. As a result, inclusive output lane 0 equals input lane 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input vector present |
| in_ready | output | 1 | Unit can accept a vector this cycle |
| in_excl | input | 1 | 1 selects exclusive scan, 0 selects inclusive scan |
| in_data | input | LANES*W | Packed input lanes, lane i at [i*W +: W] |
| out_valid | output | 1 | Result vector present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | LANES*W | Packed result lanes, lane i at [i*W +: W] |

## Verification
A result is due `log2(LANES)` rising edges after the edge that accepts its input, provided `out_ready` stays high the whole time. The bench records the cycle count when it presents each vector. A monitor samples at falling edges and checks that each delivered vector arrives exactly that many cycles after it was sent, then compares the vector with a sum computed in the bench. When the bench stalls the output, it turns the latency check off for the vectors in flight. It then takes a snapshot one falling edge after it drops `out_ready` and compares the output against that snapshot for several cycles.

// File: rtl/lane_scan_pkg.sv
package lane_scan_pkg;
  localparam int DEF_LANES = 32;
  localparam int DEF_WIDTH = 16;

  typedef struct packed {
    logic vld;
    logic excl;
  } scan_tag_t;
endpackage

// File: rtl/lane_scan_stage.sv
module lane_scan_stage
  import lane_scan_pkg::*;
#(
  parameter int LANES  = DEF_LANES,
  parameter int W      = DEF_WIDTH,
  parameter int OFFSET = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  scan_tag_t          tag_i,
  input  logic [LANES*W-1:0] d_i,
  output scan_tag_t          tag_o,
  output logic [LANES*W-1:0] d_o
);
  localparam int LOW_BITS = OFFSET * W;

  logic [LANES*W-1:0] nxt;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    if (i >= OFFSET) begin : g_add
      assign nxt[i*W +: W] = d_i[i*W +: W] + d_i[(i-OFFSET)*W +: W];
    end else begin : g_pass
      assign nxt[i*W +: W] = d_i[i*W +: W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag_o <= '0;
      d_o   <= '0;
    end else if (en) begin
      tag_o <= tag_i;
      d_o   <= nxt;
    end
  end

  // R7
  stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(d_o) && $stable(tag_o));

  // R3
  stage_tag_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> tag_o == $past(tag_i));

  // R9
  low_lane_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> d_o[LOW_BITS-1:0] == $past(d_i[LOW_BITS-1:0]));
endmodule

// File: rtl/lane_scan_excl.sv
module lane_scan_excl #(
  parameter int LANES = 32,
  parameter int W     = 16
) (
  input  logic               excl,
  input  logic [LANES*W-1:0] incl,
  output logic [LANES*W-1:0] res
);
  assign res[W-1:0] = excl ? '0 : incl[W-1:0];

  for (genvar i = 1; i < LANES; i++) begin : g_sel
    assign res[i*W +: W] = excl ? incl[(i-1)*W +: W] : incl[i*W +: W];
  end
endmodule

// File: rtl/lane_scan_unit.sv
module lane_scan_unit
  import lane_scan_pkg::*;
#(
  parameter int LANES = DEF_LANES,
  parameter int W     = DEF_WIDTH
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic               in_excl,
  input  logic [LANES*W-1:0] in_data,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [LANES*W-1:0] out_data
);
  localparam int STAGES = $clog2(LANES);

  scan_tag_t          tag [STAGES+1];
  logic [LANES*W-1:0] dat [STAGES+1];
  logic               adv;

  assign adv      = out_ready;
  assign in_ready = adv;
  assign tag[0]   = '{vld: in_valid, excl: in_excl};
  assign dat[0]   = in_data;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    lane_scan_stage #(
      .LANES (LANES),
      .W     (W),
      .OFFSET(1 << s)
    ) u_stage (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (adv),
      .tag_i(tag[s]),
      .d_i  (dat[s]),
      .tag_o(tag[s+1]),
      .d_o  (dat[s+1])
    );
  end

  assign out_valid = tag[STAGES].vld;

  lane_scan_excl #(
    .LANES(LANES),
    .W    (W)
  ) u_excl (
    .excl(tag[STAGES].excl),
    .incl(dat[STAGES]),
    .res (out_data)
  );

  // R7
  out_stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
endmodule

// File: tb/tb_lane_scan_unit.sv
module tb_lane_scan_unit;
  localparam int LANES  = 32;
  localparam int W      = 16;
  localparam int STAGES = $clog2(LANES);
  localparam int PERIOD = 10;
  localparam int NTBL   = 8;
  localparam int MAXV   = 64;

  // {wrap case, exclusive, base, step}: lane i = base + step*i
  localparam logic [33:0] VEC_TBL [NTBL] = '{
    {1'b0, 1'b0, 16'h0001, 16'h0001},
    {1'b0, 1'b1, 16'h0001, 16'h0001},
    {1'b1, 1'b0, 16'hFFFF, 16'h0000},
    {1'b1, 1'b1, 16'hFFFF, 16'h0001},
    {1'b0, 1'b0, 16'h0000, 16'h0000},
    {1'b0, 1'b1, 16'h0007, 16'h0003},
    {1'b1, 1'b0, 16'h8000, 16'h8000},
    {1'b1, 1'b1, 16'h1234, 16'hABCD}
  };

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               in_valid = 1'b0;
  logic               in_ready;
  logic               in_excl = 1'b0;
  logic [LANES*W-1:0] in_data = '0;
  logic               out_valid;
  logic               out_ready = 1'b1;
  logic [LANES*W-1:0] out_data;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;
  int tx_idx = 0;
  int rx_idx = 0;
  logic [LANES*W-1:0] exp_mem [MAXV];
  int                 tx_cyc  [MAXV];
  bit                 lat_on  [MAXV];
  string              req_of  [MAXV];

  lane_scan_unit #(.LANES(LANES), .W(W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_excl(in_excl), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  always #(PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [LANES*W-1:0] make_vec(input logic [15:0] base,
                                                   input logic [15:0] step);
    logic [LANES*W-1:0] v;
    for (int i = 0; i < LANES; i++) v[i*W +: W] = W'(base + step * i);
    return v;
  endfunction

  function automatic logic [LANES*W-1:0] ref_scan(input logic [LANES*W-1:0] v,
                                                  input bit ex);
    logic [LANES*W-1:0] r;
    logic [W-1:0] acc;
    acc = '0;
    for (int i = 0; i < LANES; i++) begin
      if (ex) begin
        r[i*W +: W] = acc;
        acc = acc + v[i*W +: W];
      end else begin
        acc = acc + v[i*W +: W];
        r[i*W +: W] = acc;
      end
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [LANES*W-1:0] act, input logic [LANES*W-1:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // drive point: just after a falling edge
  task automatic send(input logic [LANES*W-1:0] v, input bit ex,
                      input string req, input bit lat);
    in_valid = 1'b1;
    in_excl  = ex;
    in_data  = v;
    exp_mem[tx_idx] = ref_scan(v, ex);
    tx_cyc[tx_idx]  = cyc;
    lat_on[tx_idx]  = lat;
    req_of[tx_idx]  = req;
    tx_idx++;
    @(negedge clk); #1;
  endtask

  task automatic idle();
    in_valid = 1'b0;
    in_data  = '0;
  endtask

  // result monitor (R1 R2 R3 R4 R5 R6)
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (rx_idx >= tx_idx) begin
        check(1'b0, "R6", "unexpected result", out_data, '0);
      end else begin
        check(out_data == exp_mem[rx_idx], req_of[rx_idx], "scan result",
              out_data, exp_mem[rx_idx]);
        if (lat_on[rx_idx])
          check(cyc - tx_cyc[rx_idx] == STAGES, "R5", "latency",
                LANES*W'(cyc - tx_cyc[rx_idx]), LANES*W'(STAGES));
        rx_idx <= rx_idx + 1;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL R5 watchdog: actual no completion expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [LANES*W-1:0] snap;
    logic [LANES*W-1:0] v;
    logic [33:0] e;
    // reset state (R8)
    repeat (2) @(negedge clk);
    check(out_valid == 1'b0, "R8", "out_valid in reset", LANES*W'(out_valid), '0);
    check(in_ready == 1'b1, "R8", "in_ready follows out_ready", LANES*W'(in_ready), 1);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R8", "out_valid after reset", LANES*W'(out_valid), '0);
    #1 out_ready = 1'b0;
    @(negedge clk);
    check(in_ready == 1'b0, "R7", "in_ready low with out_ready low", LANES*W'(in_ready), '0);
    #1 out_ready = 1'b1;

    // table walk, back to back (R1 R2 R4 R5 R6)
    for (int k = 0; k < NTBL; k++) begin
      e = VEC_TBL[k];
      v = make_vec(e[31:16], e[15:0]);
      send(v, e[32], e[33] ? "R4" : (e[32] ? "R2" : "R1"), 1'b1);
    end
    idle();
    repeat (STAGES + 2) @(negedge clk);

    // lane 0 passes through (R9) and the 1..8 example (R1)
    v = make_vec(16'd1, 16'd1);
    send(v, 1'b0, "R9", 1'b1);
    idle();
    repeat (STAGES - 1) @(negedge clk);
    check(out_data[W-1:0] == v[W-1:0], "R9", "lane 0 unchanged",
          LANES*W'(out_data[W-1:0]), LANES*W'(v[W-1:0]));
    check(out_data[7*W +: W] == 16'd36, "R1", "lane 7 of 1..8",
          LANES*W'(out_data[7*W +: W]), 36);
    repeat (3) @(negedge clk); #1;

    // mixed modes back to back, then stall (R3 R7)
    v = make_vec(16'h0101, 16'h0022);
    send(v, 1'b1, "R3", 1'b0);
    send(v, 1'b0, "R3", 1'b0);
    send(v, 1'b1, "R3", 1'b0);
    idle();
    repeat (2) @(negedge clk);
    #1 out_ready = 1'b0;
    @(negedge clk);
    snap = out_data;
    check(out_valid == 1'b1, "R7", "valid at stall start", LANES*W'(out_valid), 1);
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      check(in_ready == 1'b0, "R7", "in_ready during stall", LANES*W'(in_ready), '0);
      check(out_valid == 1'b1 && out_data == snap, "R7", "output held",
            out_data, snap);
    end
    #1 out_ready = 1'b1;

    wait (rx_idx == tx_idx);
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule